// File: doc/BRIEF.md
# IN Endpoint Transmit Control

This block holds the control and status logic for one device-side USB transmit (IN) endpoint. The endpoint's packet buffer holds one or two packets. A processor loads packets into the buffer, which sits outside this block. It tells the block about each packet, and it steers the endpoint through an 8-bit control/status byte. That byte mixes three kinds of bit: level bits, sticky flags that are cleared by writing 0, and strobes that act when written 1.

The token side of the block reports three things: IN tokens, ACK handshakes from the host, and the end of each isochronous microframe. For every IN token, the block registers one response for the packet engine: DATA, NAK, STALL or a zero-length packet. It also tracks the DATA0/DATA1 toggle and counts how many packets are queued. It detects underrun, stall and high-bandwidth isochronous shortfall, and it pulses an interrupt request when a packet completes or is flushed.

Every result is registered. Status bits, the response and the interrupt all appear one clock after the cycle that caused them.

Top module: `txep_ctrl`

## Requirements
- R1: After reset, `reg_rdata` is 0x00, `rsp_valid` is 0 and `irq` is 0.
- R2: Writing a byte with bit 0 set and bit 3 clear queues one packet. The queue holds 2 packets when `cfg_dbl` is 1 and 1 packet otherwise, and a load into a full queue is ignored. Read bit 0 (packet ready) is 1 only while the queue is full. Read bit 1 (not empty) is 1 while at least one packet is queued.
- R3: When an IN token arrives with a packet queued and no active stall, `rsp_valid` is 1 with `rsp_kind` = 0 (DATA). In non-isochronous mode, `rsp_pid1` equals the current data toggle (1 = DATA1).
- R4: In non-isochronous mode, an ACK that follows a DATA response releases the oldest packet and flips the toggle. An ACK with no DATA outstanding has no effect.
- R5: In non-isochronous mode, an IN token that arrives before the ACK re-sends DATA with the same toggle, and the packet stays queued.
- R6: An IN token with no packet queued (and no active stall) sets read bit 2 (underrun). The response is `rsp_kind` = 1 (NAK) in non-isochronous mode and 3 (zero-length) in isochronous mode. Writing 0 to bit 2 clears underrun, and writing 1 to bit 2 leaves it as it is.
- R7: Bit 4 (stall request) takes the written value. While it is 1 and `cfg_iso` is 0, every IN token gets `rsp_kind` = 2 (STALL), sets read bit 5 (stall sent) and empties the queue. In isochronous mode the stall request has no effect. Writing 0 to bit 5 clears stall sent.
- R8: Writing 1 to bit 3 alone drops the newest queued packet. With two packets queued, two such writes empty the queue. Writing bits 3 and 0 together leaves the count unchanged. Bits 3 and 6 always read 0.
- R9: Writing 1 to bit 6 forces the data toggle to DATA0.
- R10: In isochronous mode, DATA responses have `rsp_pid1` = 0 and need no ACK. A packet is released after N IN tokens, where N = `cfg_parts` (0 is taken as 1).
- R11: In isochronous mode, a microframe end that comes after 1 to N-1 parts of a packet have been sent sets read bit 7 (incomplete) and drops that packet. Bit 7 reads 0 whenever `cfg_iso` is 0, and writing 0 to bit 7 clears it.
- R12: `irq` pulses for one cycle on packet completion (an ACK release, or the last isochronous part) and on any write with bit 3 set, but only while `int_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_iso | input | 1 | Endpoint is in isochronous mode |
| cfg_dbl | input | 1 | Two-packet buffering |
| cfg_parts | input | PART_W (2) | Transactions per isochronous packet |
| int_en | input | 1 | Interrupt enable |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Status byte |
| tok_in | input | 1 | IN token received |
| tok_ack | input | 1 | ACK handshake received |
| tok_uf_end | input | 1 | Microframe end |
| rsp_valid | output | 1 | Response issued for the previous cycle's token |
| rsp_kind | output | 2 | 0 DATA, 1 NAK, 2 STALL, 3 zero-length |
| rsp_pid1 | output | 1 | DATA1 toggle for a DATA response |
| irq | output | 1 | Interrupt request pulse |

## Verification
Every output of this block is due exactly one rising edge after the stimulus that causes it. This covers the status byte after a write or token, the response after an IN token, and the interrupt after an ACK, the last isochronous part or a flush. The bench therefore drives each stimulus at a falling edge and steps its reference model once for that stimulus. It then compares every output at the following falling edge. Simultaneous token events that the requirements leave unordered are never driven in the same cycle.

// File: rtl/txep_pkg.sv
package txep_pkg;

   typedef enum logic [1:0] {
      RSP_DATA  = 2'd0,
      RSP_NAK   = 2'd1,
      RSP_STALL = 2'd2,
      RSP_ZLP   = 2'd3
   } rsp_e;

   // Positions in the control/status byte
   localparam int BIT_RDY  = 0;
   localparam int BIT_NEMP = 1;
   localparam int BIT_UNDR = 2;
   localparam int BIT_FLSH = 3;
   localparam int BIT_SREQ = 4;
   localparam int BIT_SDONE = 5;
   localparam int BIT_CTOG = 6;
   localparam int BIT_INC  = 7;

endpackage

// File: rtl/txep_slots.sv
module txep_slots #(
   parameter int MAX_SLOTS = 2,
   parameter int CNT_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_dbl,
   input  logic             load,
   input  logic             flush_dec,
   input  logic             pop,
   input  logic             drop_all,
   output logic [CNT_W-1:0] cnt,
   output logic             full,
   output logic             empty
);

   logic [CNT_W-1:0] cap;
   logic [CNT_W:0]   grow;
   logic [CNT_W:0]   shrink;
   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (MAX_SLOTS == 1) begin : g_single
         assign cap = CNT_W'(1);
      end else begin : g_multi
         assign cap = cfg_dbl ? CNT_W'(MAX_SLOTS) : CNT_W'(1);
      end
   endgenerate

   assign full  = (cnt >= cap);
   assign empty = (cnt == '0);

   always_comb begin
      grow   = {1'b0, cnt} + {{CNT_W{1'b0}}, (load & ~full)};
      shrink = {{CNT_W{1'b0}}, pop} + {{CNT_W{1'b0}}, flush_dec};
      if (drop_all)
         cnt_nxt = '0;
      else if (grow > shrink)
         cnt_nxt = CNT_W'(grow - shrink);
      else
         cnt_nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

endmodule

// File: rtl/txep_resp.sv
module txep_resp
   import txep_pkg::*;
#(
   parameter int HB_MAX = 3,
   parameter int PART_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_iso,
   input  logic [PART_W-1:0] cfg_parts,
   input  logic              tok_in,
   input  logic              tok_ack,
   input  logic              tok_uf_end,
   input  logic              stall_req,
   input  logic              empty,
   input  logic              clr_tog,
   input  logic              flush_wr,
   output logic              rsp_valid,
   output logic [1:0]        rsp_kind,
   output logic              rsp_pid1,
   output logic              ev_stall,
   output logic              ev_under,
   output logic              ev_done,
   output logic              ev_incomp
);

   logic              tog;
   logic              pend;
   logic [PART_W-1:0] parts;
   logic [PART_W-1:0] tgt;
   logic              stall_on;
   logic              send;
   logic              ack_pop;
   logic              iso_last;
   logic              abort;
   rsp_e              kind_nxt;

   always_comb begin
      if (cfg_parts == '0)
         tgt = PART_W'(1);
      else if (int'(cfg_parts) > HB_MAX)
         tgt = PART_W'(HB_MAX);
      else
         tgt = cfg_parts;
   end

   assign stall_on  = stall_req & ~cfg_iso;
   assign ev_stall  = tok_in & stall_on;
   assign ev_under  = tok_in & ~stall_on & empty;
   assign send      = tok_in & ~stall_on & ~empty;
   assign ack_pop   = tok_ack & pend & ~cfg_iso;
   assign iso_last  = send & cfg_iso &
                      (({1'b0, parts} + {{PART_W{1'b0}}, 1'b1}) >= {1'b0, tgt});
   assign ev_incomp = tok_uf_end & cfg_iso & ~send & (parts != '0);
   assign ev_done   = ack_pop | iso_last;
   assign abort     = flush_wr | ev_stall;

   always_comb begin
      if (ev_stall)       kind_nxt = RSP_STALL;
      else if (ev_under)  kind_nxt = cfg_iso ? RSP_ZLP : RSP_NAK;
      else                kind_nxt = RSP_DATA;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_kind  <= RSP_DATA;
         rsp_pid1  <= 1'b0;
      end else begin
         rsp_valid <= tok_in;
         rsp_kind  <= kind_nxt;
         rsp_pid1  <= send & ~cfg_iso & tog;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tog <= 1'b0;
      else if (clr_tog) tog <= 1'b0;
      else if (ack_pop) tog <= ~tog;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pend <= 1'b0;
      else if (abort)             pend <= 1'b0;
      else if (send & ~cfg_iso)   pend <= 1'b1;
      else if (ack_pop)           pend <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         parts <= '0;
      else if (abort | ev_incomp | iso_last)
         parts <= '0;
      else if (send & cfg_iso)
         parts <= parts + PART_W'(1);
   end

endmodule

// File: rtl/txep_regs.sv
module txep_regs
   import txep_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_iso,
   input  logic              int_en,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              ev_stall,
   input  logic              ev_under,
   input  logic              ev_done,
   input  logic              ev_incomp,
   input  logic              full,
   input  logic              empty,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              stall_req,
   output logic              load,
   output logic              flush_wr,
   output logic              flush_dec,
   output logic              clr_tog,
   output logic              irq
);

   logic stall_done;
   logic underrun;
   logic incomp;

   assign flush_wr  = reg_wr & reg_wdata[BIT_FLSH];
   assign load      = reg_wr & reg_wdata[BIT_RDY] & ~reg_wdata[BIT_FLSH];
   assign flush_dec = flush_wr & ~reg_wdata[BIT_RDY];
   assign clr_tog   = reg_wr & reg_wdata[BIT_CTOG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stall_req <= 1'b0;
      else if (reg_wr) stall_req <= reg_wdata[BIT_SREQ];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               stall_done <= 1'b0;
      else if (ev_stall)                        stall_done <= 1'b1;
      else if (reg_wr & ~reg_wdata[BIT_SDONE])  stall_done <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              underrun <= 1'b0;
      else if (ev_under)                       underrun <= 1'b1;
      else if (reg_wr & ~reg_wdata[BIT_UNDR])  underrun <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             incomp <= 1'b0;
      else if (ev_incomp)                     incomp <= 1'b1;
      else if (reg_wr & ~reg_wdata[BIT_INC])  incomp <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= int_en & (ev_done | flush_wr);
   end

   always_comb begin
      reg_rdata            = '0;
      reg_rdata[BIT_INC]   = incomp & cfg_iso;
      reg_rdata[BIT_SDONE] = stall_done;
      reg_rdata[BIT_SREQ]  = stall_req;
      reg_rdata[BIT_UNDR]  = underrun;
      reg_rdata[BIT_NEMP]  = ~empty;
      reg_rdata[BIT_RDY]   = full;
   end

endmodule

// File: rtl/txep_ctrl.sv
module txep_ctrl #(
   parameter int MAX_SLOTS = 2,
   parameter int HB_MAX    = 3,
   parameter int PART_W    = $clog2(HB_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_iso,
   input  logic              cfg_dbl,
   input  logic [PART_W-1:0] cfg_parts,
   input  logic              int_en,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              tok_in,
   input  logic              tok_ack,
   input  logic              tok_uf_end,
   output logic              rsp_valid,
   output logic [1:0]        rsp_kind,
   output logic              rsp_pid1,
   output logic              irq
);

   localparam int CNT_W = $clog2(MAX_SLOTS + 1);

   generate
      if (MAX_SLOTS < 1 || MAX_SLOTS > 8) begin : g_bad_slots
         $error("txep_ctrl: MAX_SLOTS out of range");
      end
      if (HB_MAX < 1 || HB_MAX > 3) begin : g_bad_hb
         $error("txep_ctrl: HB_MAX must be 1 to 3");
      end
      if (PART_W < $clog2(HB_MAX + 1)) begin : g_bad_pw
         $error("txep_ctrl: PART_W too narrow");
      end
   endgenerate

   logic             stall_req, load, flush_wr, flush_dec, clr_tog;
   logic             ev_stall, ev_under, ev_done, ev_incomp;
   logic             full, empty;
   logic [CNT_W-1:0] cnt;

   txep_regs #(.DATA_W(8)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_iso   (cfg_iso),
      .int_en    (int_en),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .ev_stall  (ev_stall),
      .ev_under  (ev_under),
      .ev_done   (ev_done),
      .ev_incomp (ev_incomp),
      .full      (full),
      .empty     (empty),
      .reg_rdata (reg_rdata),
      .stall_req (stall_req),
      .load      (load),
      .flush_wr  (flush_wr),
      .flush_dec (flush_dec),
      .clr_tog   (clr_tog),
      .irq       (irq)
   );

   txep_slots #(.MAX_SLOTS(MAX_SLOTS), .CNT_W(CNT_W)) slots_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_dbl   (cfg_dbl),
      .load      (load),
      .flush_dec (flush_dec),
      .pop       (ev_done | ev_incomp),
      .drop_all  (ev_stall),
      .cnt       (cnt),
      .full      (full),
      .empty     (empty)
   );

   txep_resp #(.HB_MAX(HB_MAX), .PART_W(PART_W)) resp_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_iso    (cfg_iso),
      .cfg_parts  (cfg_parts),
      .tok_in     (tok_in),
      .tok_ack    (tok_ack),
      .tok_uf_end (tok_uf_end),
      .stall_req  (stall_req),
      .empty      (empty),
      .clr_tog    (clr_tog),
      .flush_wr   (flush_wr),
      .rsp_valid  (rsp_valid),
      .rsp_kind   (rsp_kind),
      .rsp_pid1   (rsp_pid1),
      .ev_stall   (ev_stall),
      .ev_under   (ev_under),
      .ev_done    (ev_done),
      .ev_incomp  (ev_incomp)
   );

endmodule

// File: rtl/txep_chk.sv
module txep_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_iso,
   input logic       int_en,
   input logic [7:0] reg_rdata,
   input logic       tok_in,
   input logic       rsp_valid,
   input logic [1:0] rsp_kind,
   input logic       rsp_pid1,
   input logic       irq
);

   // R3
   rsp_follows_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tok_in |=> rsp_valid);

   // R3
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_in |=> !rsp_valid);

   // R7
   stall_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_in && reg_rdata[4] && !cfg_iso) |=>
         (rsp_kind == 2'd2 && reg_rdata[5] && !reg_rdata[1]));

   // R6
   underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_in && !reg_rdata[1] && !(reg_rdata[4] && !cfg_iso)) |=>
         (reg_rdata[2] && rsp_kind != 2'd0));

   // R2
   rdy_implies_nemp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[0] |-> reg_rdata[1]);

   // R11
   incomp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_iso |-> !reg_rdata[7]);

   // R10
   iso_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_in && cfg_iso) |=> !rsp_pid1);

   // R12
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(int_en));

endmodule

bind txep_ctrl txep_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_iso   (cfg_iso),
   .int_en    (int_en),
   .reg_rdata (reg_rdata),
   .tok_in    (tok_in),
   .rsp_valid (rsp_valid),
   .rsp_kind  (rsp_kind),
   .rsp_pid1  (rsp_pid1),
   .irq       (irq)
);

// File: tb/txep_ctrl_tb.sv
`timescale 1ns/1ps
module txep_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_iso = 1'b0;
   logic       cfg_dbl = 1'b0;
   logic [1:0] cfg_parts = 2'd1;
   logic       int_en = 1'b1;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       tok_in = 1'b0;
   logic       tok_ack = 1'b0;
   logic       tok_uf_end = 1'b0;
   logic       rsp_valid;
   logic [1:0] rsp_kind;
   logic       rsp_pid1;
   logic       irq;

   always #5 clk = ~clk;

   txep_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_iso    (cfg_iso),
      .cfg_dbl    (cfg_dbl),
      .cfg_parts  (cfg_parts),
      .int_en     (int_en),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .tok_in     (tok_in),
      .tok_ack    (tok_ack),
      .tok_uf_end (tok_uf_end),
      .rsp_valid  (rsp_valid),
      .rsp_kind   (rsp_kind),
      .rsp_pid1   (rsp_pid1),
      .irq        (irq)
   );

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 0;
   string cur_req  = "R1";

   // Reference model state
   int q[$];
   bit m_sreq, m_sdone, m_under, m_inc, m_tog, m_pend;
   int m_parts;
   bit e_valid, e_pid1, e_irq;
   int e_kind;

   task automatic check(input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
      end
   endtask

   function automatic int exp_rdata();
      int cap = cfg_dbl ? 2 : 1;
      int r = 0;
      if (m_inc && cfg_iso)  r |= 8'h80;
      if (m_sdone)           r |= 8'h20;
      if (m_sreq)            r |= 8'h10;
      if (m_under)           r |= 8'h04;
      if (q.size() > 0)      r |= 8'h02;
      if (q.size() >= cap)   r |= 8'h01;
      return r;
   endfunction

   task automatic model_reset();
      q.delete();
      m_sreq = 0; m_sdone = 0; m_under = 0; m_inc = 0; m_tog = 0; m_pend = 0;
      m_parts = 0; e_valid = 0; e_kind = 0; e_pid1 = 0; e_irq = 0;
   endtask

   task automatic model_step(input bit w, input bit [7:0] d, input bit ti, input bit ta,
                             input bit uf);
      int cap = cfg_dbl ? 2 : 1;
      int tgt = (cfg_parts == 0) ? 1 : int'(cfg_parts);
      bit stall_on = m_sreq && !cfg_iso;
      bit ev_st = 0, ev_un = 0, snd = 0, ack_pop, iso_last, inc_ev, flushw;
      e_valid = ti; e_kind = 0; e_pid1 = 0;
      if (ti) begin
         if (stall_on)            begin e_kind = 2; ev_st = 1; end
         else if (q.size() == 0)  begin e_kind = cfg_iso ? 3 : 1; ev_un = 1; end
         else                     begin snd = 1; e_pid1 = !cfg_iso && m_tog; end
      end
      ack_pop  = ta && m_pend && !cfg_iso;
      iso_last = snd && cfg_iso && (m_parts + 1 >= tgt);
      inc_ev   = uf && cfg_iso && !snd && m_parts != 0;
      flushw   = w && d[3];
      if (w && d[0] && !d[3] && q.size() < cap) q.push_back(1);
      if ((ack_pop || iso_last || inc_ev) && q.size() > 0) void'(q.pop_front());
      if (w && d[3] && !d[0] && q.size() > 0) void'(q.pop_back());
      if (ev_st) q.delete();
      if (w && d[6]) m_tog = 0; else if (ack_pop) m_tog = !m_tog;
      if (flushw || ev_st) m_pend = 0;
      else if (snd && !cfg_iso) m_pend = 1;
      else if (ack_pop) m_pend = 0;
      if (flushw || ev_st || inc_ev || iso_last) m_parts = 0;
      else if (snd && cfg_iso) m_parts++;
      if (w) m_sreq = d[4];
      if (ev_st) m_sdone = 1; else if (w && !d[5]) m_sdone = 0;
      if (ev_un) m_under = 1; else if (w && !d[2]) m_under = 0;
      if (inc_ev) m_inc = 1; else if (w && !d[7]) m_inc = 0;
      e_irq = int_en && (ack_pop || iso_last || flushw);
   endtask

   task automatic compare_all();
      check("status", int'(reg_rdata), exp_rdata());
      check("rsp_valid", int'(rsp_valid), int'(e_valid));
      if (e_valid) check("rsp_kind", int'(rsp_kind), e_kind);
      check("rsp_pid1", int'(rsp_pid1), int'(e_pid1));
      check("irq", int'(irq), int'(e_irq));
   endtask

   // One cycle: drive at falling edge, model once, compare at next falling edge
   task automatic step(input bit w, input bit [7:0] d, input bit ti, input bit ta,
                       input bit uf);
      reg_wr = w; reg_wdata = d; tok_in = ti; tok_ack = ta; tok_uf_end = uf;
      model_step(w, d, ti, ta, uf);
      @(posedge clk);
      @(negedge clk);
      reg_wr = 0; reg_wdata = 8'h00; tok_in = 0; tok_ack = 0; tok_uf_end = 0;
      compare_all();
   endtask

   task automatic wr(input bit [7:0] d);  step(1, d, 0, 0, 0); endtask
   task automatic tin();                  step(0, 8'h00, 1, 0, 0); endtask
   task automatic tack();                 step(0, 8'h00, 0, 1, 0); endtask
   task automatic ufe();                  step(0, 8'h00, 0, 0, 1); endtask
   task automatic idle();                 step(0, 8'h00, 0, 0, 0); endtask

   task automatic do_reset(input bit iso, input bit dbl, input bit [1:0] parts);
      @(negedge clk);
      rst_n = 0; cfg_iso = iso; cfg_dbl = dbl; cfg_parts = parts;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // R1: reset values
      cur_req = "R1";
      do_reset(0, 0, 2'd1);
      check("reset status", int'(reg_rdata), 0);
      check("reset irq", int'(irq), 0);
      idle();

      // R2: single and double buffering, load into full queue ignored
      cur_req = "R2";
      wr(8'h01); wr(8'h01);
      check("single full", int'(reg_rdata[1:0]), 3);
      do_reset(0, 1, 2'd1);
      cur_req = "R2";
      wr(8'h01);
      check("dbl one queued", int'(reg_rdata[1:0]), 2);
      wr(8'h01); wr(8'h01);

      // R3, R5, R4: DATA, retry before ACK, ACK release, stray ACK ignored
      do_reset(0, 0, 2'd1);
      int_en = 1;
      cur_req = "R3"; wr(8'h01); tin();
      check("data kind", int'(rsp_kind), 0);
      cur_req = "R5"; tin();
      check("retry pid", int'(rsp_pid1), 0);
      cur_req = "R4"; tack();
      check("ack irq", int'(irq), 1);
      wr(8'h01);
      cur_req = "R3"; tin();
      check("pid after ack", int'(rsp_pid1), 1);
      cur_req = "R4"; tack(); tack();
      check("stray ack irq", int'(irq), 0);

      // R12: interrupt gating
      cur_req = "R12"; int_en = 0;
      wr(8'h01); tin(); tack();
      check("gated irq", int'(irq), 0);
      int_en = 1;

      // R6: underrun NAK / ZLP, write-zero clear, write-one keep
      do_reset(0, 0, 2'd1);
      cur_req = "R6"; tin();
      check("nak", int'(rsp_kind), 1);
      wr(8'h04);
      check("under kept", int'(reg_rdata[2]), 1);
      wr(8'h00);
      do_reset(1, 0, 2'd1);
      cur_req = "R6"; tin();
      check("zlp", int'(rsp_kind), 3);

      // R7: stall with two queued, clear, ISO exemption
      do_reset(0, 1, 2'd1);
      cur_req = "R7";
      wr(8'h01); wr(8'h01); wr(8'h10); tin(); tin();
      check("stall flush", int'(reg_rdata[1]), 0);
      wr(8'h30);
      wr(8'h00);
      do_reset(1, 0, 2'd1);
      cur_req = "R7";
      wr(8'h10); wr(8'h11); tin();
      check("iso ignores stall", int'(rsp_kind), 0);

      // R8: flush twice, flush+load abort
      do_reset(0, 1, 2'd1);
      cur_req = "R8";
      wr(8'h01); wr(8'h01); wr(8'h08);
      check("flush irq", int'(irq), 1);
      wr(8'h08);
      check("flush empty", int'(reg_rdata[1]), 0);
      wr(8'h01); wr(8'h09);
      check("abort load", int'(reg_rdata[1:0]), 2);

      // R9: toggle clear
      do_reset(0, 0, 2'd1);
      cur_req = "R9";
      wr(8'h01); tin(); tack(); wr(8'h40); wr(8'h01); tin();
      check("toggle cleared", int'(rsp_pid1), 0);

      // R10: high-bandwidth ISO completes after N parts; N=0 as 1
      do_reset(1, 0, 2'd3);
      cur_req = "R10";
      wr(8'h01); tin(); tin(); idle(); tin();
      check("iso done irq", int'(irq), 1);
      do_reset(1, 0, 2'd0);
      cur_req = "R10";
      wr(8'h01); tin();
      check("iso single", int'(reg_rdata[1]), 0);

      // R11: incomplete detection, masking in non-ISO, clear
      do_reset(1, 0, 2'd2);
      cur_req = "R11";
      wr(8'h01); tin(); ufe();
      check("incomp set", int'(reg_rdata[7]), 1);
      @(negedge clk); cfg_iso = 0; idle();
      check("incomp masked", int'(reg_rdata[7]), 0);
      cfg_iso = 1; idle(); wr(8'h00);
      check("incomp cleared", int'(reg_rdata[7]), 0);
      wr(8'h01); ufe();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule